// File: doc/BRIEF.md
# Near Call Return Sequencer

This block carries out near procedure linkage for a small execution core. It owns the instruction pointer, the stack pointer and the frame-base pointer. It drives one single-port stack memory. A requester hands it one operation at a time through a valid/ready handshake. The operations are call, return, frame setup and frame teardown. The block strobes a done signal in the last cycle of each operation.

A call stores the return address on the stack and then moves the instruction pointer to the target. The return address is the current instruction pointer plus the instruction length given with the request. A return reads the word the stack pointer currently addresses and makes it the new instruction pointer. The block does not check where that word came from. A return can also drop a given number of parameter bytes from the stack afterwards. Frame setup copies the stack pointer into the frame-base pointer. Frame teardown does the reverse.

Top module: `call_ret_seq`

## Requirements
- R1: After reset, req_ready is 1, done_o and mem_en are 0, and ip_o, sp_o and bp_o hold the parameters IP_INIT, SP_INIT and BP_INIT.
- R2: A call is encoded as req_op = 0. In the cycle after acceptance, the block issues a memory write (mem_en = 1, mem_we = 1). The write goes to address sp_o minus the step and carries ip_o + req_len. After that cycle, sp_o holds the lowered value.
- R3: In the cycle after a call's write, done_o is 1. From the next cycle on, ip_o equals req_target.
- R4: A return is encoded as req_op = 1. In the cycle after acceptance, the block issues a memory read (mem_en = 1, mem_we = 0) at address sp_o, and sp_o then rises by the step. mem_rdata is valid one cycle after the read. That word becomes ip_o, whatever value it holds.
- R5: If a return's req_rel is nonzero, done_o comes one cycle after the instruction-pointer load, and sp_o then rises by req_rel more. If req_rel is zero, done_o falls in the same cycle as the load.
- R6: The step is 4 bytes when req_wide = 0 and 8 bytes when req_wide = 1. It is captured at acceptance. Stack words are AW bits wide.
- R7: Frame setup is encoded as req_op = 2. It asserts done_o one cycle after acceptance and copies sp_o into bp_o. ip_o and sp_o do not change.
- R8: Frame teardown is encoded as req_op = 3. It asserts done_o one cycle after acceptance and copies bp_o into sp_o.
- R9: req_ready is 0 from the cycle after acceptance through the done cycle. A request presented during that time is ignored. req_ready returns to 1 in the cycle after done.
- R10: done_o is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 2 | 0 call, 1 return, 2 frame setup, 3 frame teardown |
| req_target | input | AW | Call destination |
| req_len | input | LW | Length of the calling instruction |
| req_rel | input | CW | Bytes released after a return |
| req_wide | input | 1 | Stack step select: 0 gives 4 bytes, 1 gives 8 bytes |
| done_o | output | 1 | One-cycle completion strobe |
| ip_o | output | AW | Instruction pointer |
| sp_o | output | AW | Stack pointer |
| bp_o | output | AW | Frame-base pointer |
| mem_en | output | 1 | Stack memory access enable |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Stack memory byte address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, valid one cycle after a read |

## Verification
On a return, the instruction-pointer load and the done strobe share a cycle only when the release count is zero. With a nonzero count they split across two cycles. The random stream draws release counts that are often zero and sometimes nonzero. Each return is timed from acceptance to done, and the 2 or 3 cycles seen are judged against the count that was presented. The final stack pointer is checked against the step plus the count. A directed case first overwrites the stack slot under the pointer. The return must then load that value as the new instruction pointer.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    OP_CALL  = 2'd0,
    OP_RET   = 2'd1,
    OP_SETF  = 2'd2,
    OP_DROPF = 2'd3
  } crs_op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PUSH  = 3'd1,
    S_JUMP  = 3'd2,
    S_POP   = 3'd3,
    S_LOAD  = 3'd4,
    S_FREE  = 3'd5,
    S_SETF  = 3'd6,
    S_DROPF = 3'd7
  } crs_st_e;
endpackage

// File: rtl/crs_fsm.sv
module crs_fsm
  import crs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic [1:0] req_op,
  input  logic    rel_zero,
  output crs_st_e st_o,
  output logic    ready_o,
  output logic    acc_o,
  output logic    done_o
);
  crs_st_e st_q, st_d;

  assign ready_o = (st_q == S_IDLE);
  assign acc_o   = ready_o & req_valid;
  assign st_o    = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          case (crs_op_e'(req_op))
            OP_CALL:  st_d = S_PUSH;
            OP_RET:   st_d = S_POP;
            OP_SETF:  st_d = S_SETF;
            default:  st_d = S_DROPF;
          endcase
        end
      end
      S_PUSH:  st_d = S_JUMP;
      S_POP:   st_d = S_LOAD;
      S_LOAD:  st_d = rel_zero ? S_IDLE : S_FREE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      S_JUMP, S_FREE, S_SETF, S_DROPF: done_o = 1'b1;
      S_LOAD:  done_o = rel_zero;
      default: done_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // R3
  call_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PUSH) |=> done_o);
  // R9
  busy_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |=> !ready_o);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && ready_o));
endmodule

// File: rtl/crs_dp.sv
module crs_dp
  import crs_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 4,
  parameter int CW = 16,
  parameter logic [AW-1:0] IP_INIT = '0,
  parameter logic [AW-1:0] SP_INIT = '0,
  parameter logic [AW-1:0] BP_INIT = '0
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  crs_st_e       st,
  input  logic [AW-1:0] req_target,
  input  logic [LW-1:0] req_len,
  input  logic [CW-1:0] req_rel,
  input  logic          req_wide,
  output logic          rel_zero,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic [AW-1:0] ip_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] bp_o
);
  localparam logic [AW-1:0] STEP_N = AW'(4);
  localparam logic [AW-1:0] STEP_W = AW'(8);

  logic [AW-1:0] ip_q, ip_d, sp_q, sp_d, bp_q, bp_d;
  logic [AW-1:0] tgt_q, step;
  logic [LW-1:0] len_q;
  logic [CW-1:0] rel_q;
  logic          wide_q;

  assign step     = wide_q ? STEP_W : STEP_N;
  assign rel_zero = (rel_q == '0);

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      len_q  <= '0;
      rel_q  <= '0;
      wide_q <= 1'b0;
    end else if (acc) begin
      tgt_q  <= req_target;
      len_q  <= req_len;
      rel_q  <= req_rel;
      wide_q <= req_wide;
    end
  end

  always_comb begin
    ip_d = ip_q;
    sp_d = sp_q;
    bp_d = bp_q;
    case (st)
      S_PUSH:  sp_d = sp_q - step;
      S_JUMP:  ip_d = tgt_q;
      S_POP:   sp_d = sp_q + step;
      S_LOAD:  ip_d = mem_rdata;
      S_FREE:  sp_d = sp_q + AW'(rel_q);
      S_SETF:  bp_d = sp_q;
      S_DROPF: sp_d = bp_q;
      default: ;
    endcase
  end

  always_comb begin
    mem_en    = (st == S_PUSH) || (st == S_POP);
    mem_we    = (st == S_PUSH);
    mem_addr  = (st == S_PUSH) ? (sp_q - step) : sp_q;
    mem_wdata = ip_q + AW'(len_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= IP_INIT;
      sp_q <= SP_INIT;
      bp_q <= BP_INIT;
    end else begin
      ip_q <= ip_d;
      sp_q <= sp_d;
      bp_q <= bp_d;
    end
  end

  assign ip_o = ip_q;
  assign sp_o = sp_q;
  assign bp_o = bp_q;

  // R2
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (sp_q == $past(mem_addr)));
  // R4
  pop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_en && !mem_we, 2) |-> (ip_q == $past(mem_rdata)));
  // R7
  frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETF) |=> (bp_q == $past(sp_q) && $stable(sp_q)));
endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq
  import crs_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 4,
  parameter int CW = 16,
  parameter logic [AW-1:0] IP_INIT = AW'(32'h0000_0100),
  parameter logic [AW-1:0] SP_INIT = AW'(32'h0000_1000),
  parameter logic [AW-1:0] BP_INIT = AW'(32'h0000_2000)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_target,
  input  logic [LW-1:0] req_len,
  input  logic [CW-1:0] req_rel,
  input  logic          req_wide,
  output logic          done_o,
  output logic [AW-1:0] ip_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] bp_o,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata
);
  logic    rst_s1, rst_s2;
  logic    acc, rel_zero;
  crs_st_e st;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  crs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_s2),
    .req_valid (req_valid),
    .req_op    (req_op),
    .rel_zero  (rel_zero),
    .st_o      (st),
    .ready_o   (req_ready),
    .acc_o     (acc),
    .done_o    (done_o)
  );

  crs_dp #(
    .AW(AW), .LW(LW), .CW(CW),
    .IP_INIT(IP_INIT), .SP_INIT(SP_INIT), .BP_INIT(BP_INIT)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_s2),
    .acc        (acc),
    .st         (st),
    .req_target (req_target),
    .req_len    (req_len),
    .req_rel    (req_rel),
    .req_wide   (req_wide),
    .rel_zero   (rel_zero),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .ip_o       (ip_o),
    .sp_o       (sp_o),
    .bp_o       (bp_o)
  );

  // R8
  drop_frame_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    (st == S_DROPF) |=> (sp_o == $past(bp_o) && done_o == 1'b0));
endmodule

// File: tb/call_ret_seq_tb_top.sv
module call_ret_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_wide, done_o;
  logic [1:0]  req_op;
  logic [31:0] req_target, ip_o, sp_o, bp_o, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  req_len;
  logic [15:0] req_rel;
  logic        mem_en, mem_we;

  logic [31:0] bmem [256];
  logic [31:0] e_ip, e_sp, e_bp;
  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  call_ret_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_target(req_target), .req_len(req_len),
    .req_rel(req_rel), .req_wide(req_wide), .done_o(done_o),
    .ip_o(ip_o), .sp_o(sp_o), .bp_o(bp_o), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // stack memory model with one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[9:2]];
    end
  end

  function automatic logic [31:0] step_of(input logic w);
    return w ? 32'd8 : 32'd4;
  endfunction

  function automatic int cycles_of(input logic [1:0] op, input logic [15:0] rel);
    case (op)
      2'd0:    return 2;
      2'd1:    return (rel == 16'd0) ? 2 : 3;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] tgt,
                       input logic [3:0] len, input logic [15:0] rel, input logic w);
    logic [31:0] st;
    int cyc;
    st = step_of(w);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_op = op; req_target = tgt;
    req_len = len; req_rel = rel; req_wide = w;
    @(negedge clk);
    // a conflicting request held during the busy window must be ignored
    req_op = 2'd3; req_target = 32'hDEAD_BEEF; req_rel = 16'h0040; req_wide = ~w;
    chk(req_ready == 1'b0, "R9 busy ready", {31'd0, req_ready}, 32'd0);
    if (op == 2'd0) begin
      chk(mem_en && mem_we, "R2 write issued", {30'd0, mem_en, mem_we}, 32'd3);
      chk(mem_addr == e_sp - st, "R2/R6 push addr", mem_addr, e_sp - st);
      chk(mem_wdata == e_ip + 32'(len), "R2 push data", mem_wdata, e_ip + 32'(len));
    end else if (op == 2'd1) begin
      chk(mem_en && !mem_we, "R4 read issued", {30'd0, mem_en, mem_we}, 32'd2);
      chk(mem_addr == e_sp, "R4 pop addr", mem_addr, e_sp);
    end
    case (op)
      2'd0: begin e_sp = e_sp - st; e_ip = tgt; end
      2'd1: begin e_ip = bmem[e_sp[9:2]]; e_sp = e_sp + st + 32'(rel); end
      2'd2: e_bp = e_sp;
      default: e_sp = e_bp;
    endcase
    cyc = 1;
    while (!done_o && cyc < 8) begin
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(cyc == cycles_of(op, rel), (op == 2'd1) ? "R5 done timing" : "R3/R7/R8 done timing",
        32'(cyc), 32'(cycles_of(op, rel)));
    @(negedge clk);
    chk(done_o == 1'b0 && req_ready == 1'b1, "R10/R9 single strobe",
        {30'd0, done_o, req_ready}, 32'd1);
    chk(ip_o == e_ip, (op == 2'd1) ? "R4 ip" : "R3 ip", ip_o, e_ip);
    chk(sp_o == e_sp, (op == 2'd3) ? "R8 sp" : "R5/R6 sp", sp_o, e_sp);
    chk(bp_o == e_bp, "R7 bp", bp_o, e_bp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 32'h5000_0000 + 32'(i);
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_target = '0;
    req_len = '0; req_rel = '0; req_wide = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    e_ip = 32'h0000_0100; e_sp = 32'h0000_1000; e_bp = 32'h0000_2000;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    chk(done_o == 1'b0 && mem_en == 1'b0, "R1 strobes", {30'd0, done_o, mem_en}, 32'd0);
    chk(ip_o == e_ip, "R1 ip", ip_o, e_ip);
    chk(sp_o == e_sp, "R1 sp", sp_o, e_sp);
    chk(bp_o == e_bp, "R1 bp", bp_o, e_bp);

    // directed corners
    do_op(2'd0, 32'h0000_4000, 4'd5, 16'd0, 1'b0);   // narrow call
    chk(bmem[e_sp[9:2]] == 32'h0000_0105, "R2 stored word", bmem[e_sp[9:2]], 32'h0000_0105);
    do_op(2'd0, 32'h0000_8000, 4'd15, 16'd0, 1'b1);  // wide call, R6
    do_op(2'd2, 32'h0, 4'd0, 16'd0, 1'b0);           // frame setup
    do_op(2'd1, 32'h0, 4'd0, 16'd0, 1'b1);           // return, no release
    bmem[e_sp[9:2]] = 32'hCAFE_0010;                 // R4: overwrite slot
    do_op(2'd1, 32'h0, 4'd0, 16'd12, 1'b0);          // return with release
    do_op(2'd3, 32'h0, 4'd0, 16'd0, 1'b0);           // frame teardown
    do_op(2'd1, 32'h0, 4'd0, 16'hFFFF, 1'b1);        // max release

    // random stream
    for (int k = 0; k < 400; k++) begin
      logic [1:0]  op;
      logic [15:0] rel;
      op  = 2'($urandom_range(0, 3));
      rel = ($urandom_range(0, 2) == 0) ? 16'($urandom_range(1, 64)) : 16'd0;
      do_op(op, $urandom, 4'($urandom_range(1, 15)), rel, 1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule